// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the configuration store of an interrupt distributor. It sits behind a plain 32-bit register port with per-byte write strobes. Each interrupt line has a set of stored fields: an enable bit, a pending bit, a group bit, an 8-bit priority and an 8-bit CPU target mask. The block drives all of these onto wide output vectors for the arbitration logic that follows it. It also holds a small control word with two group-forwarding enables, and a read-only type word that reports its own size.

Software changes enable and pending state through paired aliases, one that sets and one that clears. A zero bit in a write to either alias has no effect, so separate agents can update different lines without a read-modify-write. Bits for lines that do not exist read as zero and ignore writes. Software can therefore find the line count by writing all ones to a set alias and reading it back.

Peripheral input lines (those at or above the per-CPU range) mark their interrupt pending on a rising level. Lines inside the per-CPU range ignore their inputs. Writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `irq_dist_regs`

## Requirements
- R1: A write to the set-enable word at 0x100 + 4*w sets the enable bits of lines 32*w + b for every bit b written as one. Zero bits leave state unchanged. Reading the set-enable or the clear-enable word of index w returns the current enable bits.
- R2: A write to the clear-enable word at 0x180 + 4*w clears only the enable bits written as one.
- R3: The set-pending word at 0x200 + 4*w and the clear-pending word at 0x280 + 4*w set and clear pending bits in the same way. Reading either word returns the current pending bits.
- R4: The group word at 0x080 + 4*w is plain read/write storage, one bit per line, updated only in byte lanes whose strobe is high.
- R5: A rising level on input line n ≥ 32 sets pending bit n at the next edge, whether or not the line is enabled. In the same cycle it takes precedence over a clear. A level held high does not set the bit again. Lines below 32 never change pending state from their inputs.
- R6: Bits, bytes and words for lines at or beyond the line count (64 by default) read as zero and ignore writes. Writing all ones to set-enable word 1 reads back 0xFFFFFFFF. The same write to word 2 (0x108) reads back zero.
- R7: The type word at 0x004 reads the number of implemented 32-line words minus one in bits [4:0] (value 1 by default) and zero elsewhere. Writes to it are ignored.
- R8: In the control word at 0x000, bit 0 enables group 0 forwarding and bit 1 enables group 1 forwarding; both drive output pins. The other bits read zero.
- R9: The priority byte of line id sits at 0x400 + id, which is word id/4, byte lane id mod 4. A write updates only the lanes whose strobe is high.
- R10: The target mask of line id sits at 0x800 + 4*(id/4), byte lane id mod 4, with the same strobe rule.
- R11: After reset, all enable, pending and group bits, priorities, targets and control bits are zero.
- R12: A write is visible on the outputs and on reads after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the register word (bits [1:0] ignored) |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NLINES | Interrupt input levels, one per line |
| grp0_fwd_o | output | 1 | Control: group 0 forwarding enabled |
| grp1_fwd_o | output | 1 | Control: group 1 forwarding enabled |
| en_o | output | NLINES | Enable bit per line |
| pend_o | output | NLINES | Pending bit per line |
| grp_o | output | NLINES | Group bit per line |
| prio_o | output | 8*NLINES | Priority byte per line, line n at [8n+7:8n] |
| tgt_o | output | 8*NLINES | CPU target mask per line, line n at [8n+7:8n] |

## Verification
The bench writes data with mixed one and zero bits to each alias and checks that the opposite bits survive. A bank that treated an alias as a plain register would wipe them. It probes the word just past the last line and the priority word just past the last byte. A bank that decoded the word index modulo its size would alias those writes onto real lines and read back nonzero. It raises a peripheral input in the same cycle as a clear-pending write to that line, and holds another input high across a clear. A wrong precedence, or level-sensitive setting, shows up as a missing pending bit or one that reappears. Randomly strobed byte writes into the priority and target regions expose lane-to-line mapping errors.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NLINES = 64,
  parameter int PERCPU = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [11:0]         bus_addr,
  input  logic [3:0]          bus_be,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NLINES-1:0]   irq_in,
  output logic                grp0_fwd_o,
  output logic                grp1_fwd_o,
  output logic [NLINES-1:0]   en_o,
  output logic [NLINES-1:0]   pend_o,
  output logic [NLINES-1:0]   grp_o,
  output logic [8*NLINES-1:0] prio_o,
  output logic [8*NLINES-1:0] tgt_o
);
  localparam int WORDS = (NLINES + 31) / 32;
  localparam int VW    = WORDS * 32;
  localparam int BW    = ((NLINES + 3) / 4) * 32;
  localparam logic [VW-1:0] IMPL   = {VW{1'b1}} >> (VW - NLINES);
  localparam logic [VW-1:0] SHARED = IMPL & ({VW{1'b1}} << PERCPU);

  logic [VW-1:0]     en_q, pend_q, grp_q;
  logic [BW-1:0]     prio_q, tgt_q;
  logic [1:0]        ctl_q;
  logic [NLINES-1:0] irq_prev;

  wire [4:0]  region = bus_addr[11:7];
  wire [4:0]  vword  = bus_addr[6:2];
  wire [7:0]  bword  = bus_addr[9:2];
  wire [1:0]  zone   = bus_addr[11:10];
  wire [9:0]  vsh    = {vword, 5'd0};
  wire [12:0] bsh    = {bword, 5'd0};

  wire [31:0] lane_m = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [VW-1:0] wvec = VW'(bus_wdata & lane_m) << vsh;
  wire [VW-1:0] mvec = VW'(lane_m) << vsh;

  wire hit_grp = bus_we && region == 5'd1;
  wire hit_sen = bus_we && region == 5'd2;
  wire hit_cen = bus_we && region == 5'd3;
  wire hit_spd = bus_we && region == 5'd4;
  wire hit_cpd = bus_we && region == 5'd5;
  wire hit_ctl = bus_we && bus_addr[11:2] == 10'd0 && bus_be[0];
  wire hit_pri = bus_we && zone == 2'b01;
  wire hit_tgt = bus_we && zone == 2'b10;

  wire [VW-1:0] rise = VW'(irq_in & ~irq_prev) & SHARED;

  wire [VW-1:0] en_d   = (en_q | (hit_sen ? wvec : '0)) & ~(hit_cen ? wvec : '0) & IMPL;
  wire [VW-1:0] pend_d = (((pend_q | (hit_spd ? wvec : '0)) & ~(hit_cpd ? wvec : '0)) | rise) & IMPL;
  wire [VW-1:0] grp_d  = ((grp_q & ~(hit_grp ? mvec : '0)) | (hit_grp ? wvec : '0)) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      grp_q    <= '0;
      ctl_q    <= '0;
      irq_prev <= '0;
      prio_q   <= '0;
      tgt_q    <= '0;
    end else begin
      en_q     <= en_d;
      pend_q   <= pend_d;
      grp_q    <= grp_d;
      irq_prev <= irq_in;
      if (hit_ctl) ctl_q <= bus_wdata[1:0];
      for (int i = 0; i < NLINES; i++) begin
        if (bword == 8'(i / 4) && bus_be[i % 4]) begin
          if (hit_pri) prio_q[8*i +: 8] <= bus_wdata[8*(i % 4) +: 8];
          if (hit_tgt) tgt_q[8*i +: 8]  <= bus_wdata[8*(i % 4) +: 8];
        end
      end
    end
  end

  wire [VW-1:0] en_rd   = en_q >> vsh;
  wire [VW-1:0] pend_rd = pend_q >> vsh;
  wire [VW-1:0] grp_rd  = grp_q >> vsh;
  wire [BW-1:0] prio_rd = prio_q >> bsh;
  wire [BW-1:0] tgt_rd  = tgt_q >> bsh;

  always_comb begin
    bus_rdata = '0;
    if (zone == 2'b01)      bus_rdata = prio_rd[31:0];
    else if (zone == 2'b10) bus_rdata = tgt_rd[31:0];
    else begin
      case (region)
        5'd0: begin
          if (vword == 5'd0)      bus_rdata = {30'd0, ctl_q};
          else if (vword == 5'd1) bus_rdata = {27'd0, 5'(WORDS - 1)};
        end
        5'd1:       bus_rdata = grp_rd[31:0];
        5'd2, 5'd3: bus_rdata = en_rd[31:0];
        5'd4, 5'd5: bus_rdata = pend_rd[31:0];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign grp0_fwd_o = ctl_q[0];
  assign grp1_fwd_o = ctl_q[1];
  assign en_o   = en_q[NLINES-1:0];
  assign pend_o = pend_q[NLINES-1:0];
  assign grp_o  = grp_q[NLINES-1:0];
  assign prio_o = prio_q[8*NLINES-1:0];
  assign tgt_o  = tgt_q[8*NLINES-1:0];

  assert_set_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h100 && bus_be[0] && bus_wdata[0]) |=> en_o[0]);
  assert_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h180 && bus_be[0] && bus_wdata[0]) |=> !en_o[0]);
  assert_edge_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_in[NLINES-1]) |=> pend_o[NLINES-1]);
  assert_percpu_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pend_o[0]));
  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[11:2] == 10'd0) |=> $stable({grp1_fwd_o, grp0_fwd_o}));
  assert_prio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[11:10] == 2'b01) |=> $stable(prio_o));
endmodule

// File: tb/irq_dist_regs_test.sv
`timescale 1ns/1ps
module irq_dist_regs_test;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wd = '0;
  logic [N-1:0]  irq = '0;
  logic [31:0]   rdata;
  logic          g0, g1;
  logic [N-1:0]  en_o, pend_o, grp_o;
  logic [8*N-1:0] prio_o, tgt_o;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_en = '0, m_pend = '0, m_grp = '0, m_prev = '0;
  logic [7:0]   m_prio [N];
  logic [7:0]   m_tgt  [N];
  logic [1:0]   m_ctl = '0;

  always #2.5 clk = ~clk;

  irq_dist_regs #(.NLINES(N), .PERCPU(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_be(be),
    .bus_wdata(wd), .bus_rdata(rdata), .irq_in(irq),
    .grp0_fwd_o(g0), .grp1_fwd_o(g1), .en_o(en_o), .pend_o(pend_o),
    .grp_o(grp_o), .prio_o(prio_o), .tgt_o(tgt_o));

  function automatic logic [31:0] lanes(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w;
    logic [31:0] r = '0;
    if (a[11:2] == 10'd0) r = {30'd0, m_ctl};
    else if (a[11:2] == 10'd1) r = 32'd1;
    else if (a >= 12'h080 && a < 12'h300) begin
      w = int'(a[6:2]);
      if (w < 2) begin
        case (a[11:7])
          5'd1:       r = m_grp[32*w +: 32];
          5'd2, 5'd3: r = m_en[32*w +: 32];
          default:    r = m_pend[32*w +: 32];
        endcase
      end
    end else if (a[11:10] == 2'b01 || a[11:10] == 2'b10) begin
      w = int'(a[9:2]);
      for (int k = 0; k < 4; k++)
        if (4*w + k < N)
          r[8*k +: 8] = (a[11:10] == 2'b01) ? m_prio[4*w+k] : m_tgt[4*w+k];
    end
    return r;
  endfunction

  function automatic logic [8*N-1:0] pack(input logic pri);
    logic [8*N-1:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = pri ? m_prio[i] : m_tgt[i];
    return v;
  endfunction

  task automatic model_edge();
    logic [N-1:0] rise;
    logic [31:0]  lm, d, clr;
    int w;
    rise = irq & ~m_prev;
    rise[31:0] = '0;
    m_prev = irq;
    lm = lanes(be);
    d  = wd & lm;
    if (we) begin
      if (addr[11:2] == 10'd0 && be[0]) m_ctl = wd[1:0];
      if (addr >= 12'h080 && addr < 12'h300) begin
        w = int'(addr[6:2]);
        if (w < 2) begin
          case (addr[11:7])
            5'd1: m_grp[32*w +: 32] = (m_grp[32*w +: 32] & ~lm) | d;
            5'd2: m_en[32*w +: 32]  = m_en[32*w +: 32] | d;
            5'd3: m_en[32*w +: 32]  = m_en[32*w +: 32] & ~d;
            5'd4: m_pend[32*w +: 32] = m_pend[32*w +: 32] | d;
            5'd5: begin clr = d; m_pend[32*w +: 32] = m_pend[32*w +: 32] & ~clr; end
            default: ;
          endcase
        end
      end
      if (addr[11:10] == 2'b01 || addr[11:10] == 2'b10) begin
        w = int'(addr[9:2]);
        for (int k = 0; k < 4; k++)
          if (4*w + k < N && be[k]) begin
            if (addr[11:10] == 2'b01) m_prio[4*w+k] = wd[8*k +: 8];
            else                      m_tgt[4*w+k]  = wd[8*k +: 8];
          end
      end
    end
    m_pend = m_pend | rise;
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic [N-1:0] iv);
    @(negedge clk);
    we = w; addr = a; be = b; wd = d; irq = iv;
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    step(1'b1, a, b, d, irq);
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [8*N-1:0] act, input logic [8*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk32(tag, rdata, exp_read(a));
  endtask

  task automatic outs(input string tag);
    chkv({tag, " en_o"},   {448'd0, en_o},   {448'd0, m_en});
    chkv({tag, " pend_o"}, {448'd0, pend_o}, {448'd0, m_pend});
    chkv({tag, " grp_o"},  {448'd0, grp_o},  {448'd0, m_grp});
    chkv({tag, " prio_o"}, prio_o, pack(1'b1));
    chkv({tag, " tgt_o"},  tgt_o,  pack(1'b0));
    chk32({tag, " ctl"}, {30'd0, g1, g0}, {30'd0, m_ctl});
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] a;
    logic [N-1:0] iv;
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_tgt[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    outs("R11 reset");
    rd("R11 reset enable", 12'h100);
    rd("R11 reset priority", 12'h404);
    rd("R7 type value", 12'h004);

    wr(12'h100, 32'h0000_00F0, 4'hF);
    rd("R1 set-enable readback", 12'h100);
    rd("R1 clear alias reads enables", 12'h180);
    chk32("R12 enable visible after edge", en_o[31:0], 32'h0000_00F0);
    wr(12'h100, 32'h0000_000F, 4'hF);
    chk32("R1 zero bits keep state", en_o[31:0], 32'h0000_00FF);
    wr(12'h180, 32'h0000_0030, 4'hF);
    chk32("R2 clear only ones", en_o[31:0], 32'h0000_00CF);

    wr(12'h104, 32'hFFFF_FFFF, 4'hF);
    rd("R6 last word all ones", 12'h104);
    chk32("R6 last word value", rdata, 32'hFFFF_FFFF);
    wr(12'h108, 32'hFFFF_FFFF, 4'hF);
    rd("R6 absent word reads zero", 12'h108);
    chk32("R6 absent word value", rdata, 32'h0);
    wr(12'h440, 32'hFFFF_FFFF, 4'hF);
    rd("R6 absent priority word", 12'h440);
    outs("R6 no aliasing");

    wr(12'h004, 32'hFFFF_FFFF, 4'hF);
    rd("R7 type ignores writes", 12'h004);
    chk32("R7 type value", rdata, 32'h1);

    wr(12'h000, 32'hFFFF_FFFF, 4'hF);
    rd("R8 control bits", 12'h000);
    chk32("R8 forward pins", {30'd0, g1, g0}, 32'h3);
    wr(12'h000, 32'h0000_0002, 4'hF);
    chk32("R8 group0 off", {30'd0, g1, g0}, 32'h2);

    wr(12'h404, 32'h0000_AB00, 4'b0010);
    chk32("R9 priority of line 5", {24'd0, prio_o[8*5 +: 8]}, 32'hAB);
    rd("R9 priority word", 12'h404);
    wr(12'h820, 32'h00C3_0000, 4'b0100);
    chk32("R10 target of line 34", {24'd0, tgt_o[8*34 +: 8]}, 32'hC3);
    rd("R10 target word", 12'h820);

    wr(12'h084, 32'h1234_5678, 4'b0101);
    rd("R4 group lanes", 12'h084);

    wr(12'h200, 32'h0000_0101, 4'hF);
    rd("R3 set-pending", 12'h280);
    wr(12'h280, 32'h0000_0001, 4'hF);
    rd("R3 clear-pending", 12'h200);

    iv = irq; iv[40] = 1'b1; iv[3] = 1'b1;
    step(1'b0, 12'h0, 4'h0, 32'h0, iv);
    chk32("R5 rise sets pending line 40", {31'd0, pend_o[40]}, 32'h1);
    chk32("R5 per-CPU line ignored", {31'd0, pend_o[3]}, 32'h0);
    wr(12'h284, 32'h0000_0100, 4'hF);
    step(1'b0, 12'h0, 4'h0, 32'h0, iv);
    chk32("R5 held level does not re-set", {31'd0, pend_o[40]}, 32'h0);
    iv[50] = 1'b1;
    step(1'b1, 12'h284, 4'hF, 32'h0004_0000, iv);
    chk32("R5 edge beats clear", {31'd0, pend_o[50]}, 32'h1);
    outs("R5 after edges");

    for (int it = 0; it < 1500; it++) begin
      int sel;
      sel = int'($urandom % 10);
      case (sel)
        0, 1, 2, 3, 4: a = 12'h080 + 12'(128 * ($urandom % 5)) + 12'(4 * ($urandom % 3));
        5:       a = 12'h400 + 12'(4 * ($urandom % 18));
        6:       a = 12'h800 + 12'(4 * ($urandom % 18));
        7:       a = 12'(4 * ($urandom % 2));
        default: a = {12'($urandom) & 12'hFFC};
      endcase
      iv = irq;
      if ($urandom % 4 == 0) iv = {$urandom, $urandom};
      step(($urandom % 5) != 0, a, (($urandom % 3) == 0) ? 4'(($urandom)) : 4'hF, $urandom, iv);
      rd("R1 R3 R4 R9 R10 random read", a);
      if (it % 8 == 0) outs("R12 random outputs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule